// File: doc/BRIEF.md
# Descriptor-Table Scatter-Gather Walker

This block moves a block of bytes between a local buffer and system memory. The memory side is described by a table of 8-byte region descriptors that lives in system memory. Software, or a neighbouring controller, gives the walker a table base with `start`. It then asks for a transfer of some number of bytes in a chosen direction with `run`. The walker fetches descriptors over a generic memory request port. For each region it issues data bursts that carry the memory address, the length, the local-buffer offset and the direction. The memory side moves the data itself.

A transfer finishes in one of two ways. It is *buffer complete* when every requested byte has been covered. It is *table ended* when the descriptors run out first. The walk runs out when the last-descriptor flag has been seen, or when the walk has gone one page past the table base. A region that is only partly used stays loaded after a transfer ends. The next `run` therefore continues inside that region without fetching a new descriptor. Only a new `start` discards it.

The request port is valid/ready. Once the walker raises `mreq_valid`, it holds the request and all its fields unchanged until it sees `mreq_ready` high at a clock edge. The memory side may hold `mreq_ready` low for any number of cycles. The descriptor response port has no ready signal. The walker accepts `mrsp_valid` only while it is waiting for a fetch, and it ignores responses at any other time.

Top module: `prd_walker`

## Requirements
- R1: A descriptor fetch is a request with `mreq_desc`=1, `mreq_write`=0 and `mreq_len`=8, sent to the table pointer. In the returned 64-bit word, bits 31:0 are the region address and bits 63:32 are the control word.
- R2: The region byte count is control bits 15:1 with bit 0 taken as zero. Control bits 30:16 have no effect.
- R3: A count field of zero gives a region of 65536 bytes.
- R4: Control bit 31 marks the last descriptor. When the region is used up, bytes are still owed and that flag was seen, the result is table ended (code 2).
- R5: The table pointer grows by 8 after each fetch. When the region is used up and the pointer is 4096 or more bytes past the base, the result is table ended with no further fetch.
- R6: Each burst length is the smaller of the bytes left in the region and the bytes left in the transfer. After each burst, the region address and the buffer offset (`mreq_buf_off`, counted from 0 at each `run`) both advance by that length.
- R7: When all requested bytes are covered, the result is buffer complete (code 1). This holds even if the region and table end at the same moment.
- R8: A partly used region carries into the next `run` with no new fetch.
- R9: `start`, when idle, reloads the table pointer from `tbl_base` and discards the current region.
- R10: On data bursts, `mreq_write` equals the `run_dir` captured at `run` (1 = buffer to memory).
- R11: A request that has not been accepted keeps its valid and all its fields stable until it is.
- R12: `done` is a one-cycle pulse.
  - The first request appears two cycles after `run` is sampled.
  - `done` rises two cycles after the last burst is accepted.
  - No request is made while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load new table base, drop current region (idle only) |
| tbl_base | input | 32 | Table base address |
| run | input | 1 | Begin a transfer (idle only) |
| run_bytes | input | 17 | Bytes to transfer |
| run_dir | input | 1 | 1: buffer to memory, 0: memory to buffer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| result | output | 2 | 1 buffer complete, 2 table ended; held until next done |
| mreq_valid | output | 1 | Request valid |
| mreq_ready | input | 1 | Request accepted this edge |
| mreq_desc | output | 1 | Request is a descriptor fetch |
| mreq_write | output | 1 | Burst writes memory |
| mreq_addr | output | 32 | Memory address |
| mreq_len | output | 17 | Length in bytes |
| mreq_buf_off | output | 17 | Local buffer offset of the burst |
| mrsp_valid | input | 1 | Descriptor data valid |
| mrsp_data | input | 64 | Descriptor, little-endian |

## Verification
The first request follows a `run` two cycles after the edge that sampled it. The bench checks this by stepping falling edges: it expects `mreq_valid` low at the first one and high at the second. The `done` pulse is due two cycles after the edge that accepts the last burst. The bench stamps both events with a falling-edge cycle counter and compares the difference with 2. It then confirms that `done` has dropped one falling edge later. Descriptor responses return one cycle after acceptance, and back-pressure cases stretch each request. The bench therefore records every accepted request at the falling edge before its accepting edge and compares the logged order, rather than fixed cycle numbers.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam int REGION_BITS = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FREQ,
    ST_FWAIT,
    ST_BREQ
  } walk_st_t;

  localparam logic [1:0] RES_NONE     = 2'd0;
  localparam logic [1:0] RES_FULL     = 2'd1;
  localparam logic [1:0] RES_TBL_END  = 2'd2;
endpackage

// File: rtl/prd_desc_decode.sv
module prd_desc_decode #(
  parameter int AW       = 32,
  parameter int REG_BITS = 16,
  localparam int LEN_W   = REG_BITS + 1
) (
  input  logic [63:0]      raw,
  output logic [AW-1:0]    reg_addr,
  output logic [LEN_W-1:0] reg_len,
  output logic             reg_last
);
  logic [31:0]         ctl;
  logic [REG_BITS-1:0] cnt;

  always_comb begin
    ctl      = raw[63:32];
    cnt      = {ctl[REG_BITS-1:1], 1'b0};
    reg_addr = raw[AW-1:0];
    reg_last = ctl[31];
    if (cnt == '0) reg_len = LEN_W'(1) << REG_BITS;
    else           reg_len = {1'b0, cnt};
  end
endmodule

// File: rtl/prd_burst_calc.sv
module prd_burst_calc #(
  parameter int A_W = 17,
  parameter int B_W = 17,
  localparam int W  = (A_W > B_W) ? A_W : B_W
) (
  input  logic [A_W-1:0] region_left,
  input  logic [B_W-1:0] buffer_left,
  output logic [A_W-1:0] burst
);
  logic [W-1:0] a_ext, b_ext;

  always_comb begin
    a_ext = W'(region_left);
    b_ext = W'(buffer_left);
    if (a_ext <= b_ext) burst = region_left;
    else                burst = A_W'(buffer_left);
  end
endmodule

// File: rtl/prd_walker.sv
module prd_walker
  import prd_pkg::*;
#(
  parameter int AW         = 32,
  parameter int BUF_W      = 17,
  parameter int PAGE_BYTES = 4096,
  localparam int LEN_W     = REGION_BITS + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    tbl_base,
  input  logic             run,
  input  logic [BUF_W-1:0] run_bytes,
  input  logic             run_dir,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result,
  output logic             mreq_valid,
  input  logic             mreq_ready,
  output logic             mreq_desc,
  output logic             mreq_write,
  output logic [AW-1:0]    mreq_addr,
  output logic [LEN_W-1:0] mreq_len,
  output logic [BUF_W-1:0] mreq_buf_off,
  input  logic             mrsp_valid,
  input  logic [63:0]      mrsp_data
);
  localparam logic [AW-1:0] PAGE_LIM  = AW'(PAGE_BYTES);
  localparam logic [AW-1:0] DESC_STEP = AW'(8);

  walk_st_t         st;
  logic [AW-1:0]    base_q, tbl_ptr, cur_addr;
  logic [LEN_W-1:0] cur_len;
  logic             cur_last;
  logic [BUF_W-1:0] buf_idx, buf_left;
  logic             dir_q;
  logic [1:0]       result_q;
  logic             done_q;

  logic [AW-1:0]    d_addr;
  logic [LEN_W-1:0] d_len;
  logic             d_last;
  logic [LEN_W-1:0] burst;
  logic [AW-1:0]    walked;
  logic             page_hit;

  prd_desc_decode #(.AW(AW), .REG_BITS(REGION_BITS)) u_dec (
    .raw(mrsp_data), .reg_addr(d_addr), .reg_len(d_len), .reg_last(d_last)
  );

  prd_burst_calc #(.A_W(LEN_W), .B_W(BUF_W)) u_min (
    .region_left(cur_len), .buffer_left(buf_left), .burst(burst)
  );

  assign walked   = tbl_ptr - base_q;
  assign page_hit = walked >= PAGE_LIM;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      base_q   <= '0;
      tbl_ptr  <= '0;
      cur_addr <= '0;
      cur_len  <= '0;
      cur_last <= 1'b0;
      buf_idx  <= '0;
      buf_left <= '0;
      dir_q    <= 1'b0;
      result_q <= RES_NONE;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            base_q   <= tbl_base;
            tbl_ptr  <= tbl_base;
            cur_addr <= '0;
            cur_len  <= '0;
            cur_last <= 1'b0;
          end
          if (run) begin
            buf_idx  <= '0;
            buf_left <= run_bytes;
            dir_q    <= run_dir;
            st       <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (buf_left == '0) begin
            result_q <= RES_FULL;
            done_q   <= 1'b1;
            st       <= ST_IDLE;
          end else if (cur_len == '0) begin
            if (cur_last || page_hit) begin
              result_q <= RES_TBL_END;
              done_q   <= 1'b1;
              st       <= ST_IDLE;
            end else begin
              st <= ST_FREQ;
            end
          end else begin
            st <= ST_BREQ;
          end
        end
        ST_FREQ: begin
          if (mreq_ready) begin
            tbl_ptr <= tbl_ptr + DESC_STEP;
            st      <= ST_FWAIT;
          end
        end
        ST_FWAIT: begin
          if (mrsp_valid) begin
            cur_addr <= d_addr;
            cur_len  <= d_len;
            cur_last <= d_last;
            st       <= ST_CHECK;
          end
        end
        ST_BREQ: begin
          if (mreq_ready) begin
            cur_addr <= cur_addr + AW'(burst);
            cur_len  <= cur_len - burst;
            buf_idx  <= buf_idx + BUF_W'(burst);
            buf_left <= buf_left - BUF_W'(burst);
            st       <= ST_CHECK;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy         = (st != ST_IDLE);
    done         = done_q;
    result       = result_q;
    mreq_valid   = (st == ST_FREQ) || (st == ST_BREQ);
    mreq_desc    = (st == ST_FREQ);
    mreq_write   = (st == ST_BREQ) && dir_q;
    mreq_addr    = (st == ST_FREQ) ? tbl_ptr : cur_addr;
    mreq_len     = (st == ST_FREQ) ? LEN_W'(8) : burst;
    mreq_buf_off = buf_idx;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_addr) && $stable(mreq_len)
      && $stable(mreq_desc) && $stable(mreq_buf_off)); // R11
  AST_TBL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && mreq_desc |-> (mreq_addr - base_q) < PAGE_LIM); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mreq_valid); // R12
  AST_DONE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result == RES_FULL) || (result == RES_TBL_END)); // R7
endmodule

// File: tb/prd_walker_test.sv
module prd_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] tbl_base = '0;
  logic        run = 1'b0;
  logic [16:0] run_bytes = '0;
  logic        run_dir = 1'b0;
  logic        busy, done;
  logic [1:0]  result;
  logic        mreq_valid, mreq_desc, mreq_write;
  logic        mreq_ready = 1'b1;
  logic [31:0] mreq_addr;
  logic [16:0] mreq_len, mreq_buf_off;
  logic        mrsp_valid = 1'b0;
  logic [63:0] mrsp_data = '0;

  always #2 clk = ~clk;

  prd_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .tbl_base(tbl_base),
    .run(run), .run_bytes(run_bytes), .run_dir(run_dir),
    .busy(busy), .done(done), .result(result),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_desc(mreq_desc),
    .mreq_write(mreq_write), .mreq_addr(mreq_addr), .mreq_len(mreq_len),
    .mreq_buf_off(mreq_buf_off), .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  logic bp = 1'b0;
  logic [63:0] mem [int unsigned];

  int          f_cnt, b_cnt, last_acc;
  logic [31:0] f_addr [0:1023];
  logic [31:0] b_addr [0:1023];
  logic [16:0] b_len  [0:1023];
  logic [16:0] b_off  [0:1023];
  logic        b_wr   [0:1023];
  logic        pend = 1'b0;
  logic [63:0] pend_data = '0;
  logic [1:0]  res;
  int          done_cyc;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // memory side: ready, logging and one-cycle descriptor response
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (pend) begin
        mrsp_valid = 1'b1; mrsp_data = pend_data; pend = 1'b0;
      end else begin
        mrsp_valid = 1'b0;
      end
      mreq_ready = bp ? (cyc % 3 == 0) : 1'b1;
      if (mreq_valid && mreq_ready) begin
        last_acc = cyc;
        if (mreq_desc) begin
          if (f_cnt < 1024) f_addr[f_cnt] = mreq_addr;
          f_cnt++;
          pend_data = mem.exists(mreq_addr) ? mem[mreq_addr] : 64'h0;
          pend = 1'b1;
        end else begin
          if (b_cnt < 1024) begin
            b_addr[b_cnt] = mreq_addr; b_len[b_cnt] = mreq_len;
            b_off[b_cnt] = mreq_buf_off; b_wr[b_cnt] = mreq_write;
          end
          b_cnt++;
        end
      end
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
      end
    end
  end

  task automatic put_desc(input logic [31:0] at, input logic [31:0] ra, input logic [31:0] ctl);
    mem[at] = {ctl, ra};
  endtask

  task automatic clr_log();
    f_cnt = 0; b_cnt = 0;
  endtask

  task automatic do_start(input logic [31:0] b);
    @(negedge clk); start = 1'b1; tbl_base = b;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic do_run(input logic [16:0] n, input logic d);
    int w;
    @(negedge clk); run = 1'b1; run_bytes = n; run_dir = d;
    @(negedge clk); run = 1'b0;
    w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    done_cyc = cyc;
    res = result;
    @(negedge clk);
    chk("R12 done pulse one cycle", done, 0);
  endtask

  task automatic t_reset();
    chk("R12 reset busy", busy, 0);
    chk("R12 reset valid", mreq_valid, 0);
    chk("R12 reset done", done, 0);
    chk("R12 reset result", result, 0);
  endtask

  task automatic t_single();
    clr_log();
    put_desc(32'h1000, 32'h2000_0000, 32'h8000_0100);
    do_start(32'h1000);
    @(negedge clk); run = 1'b1; run_bytes = 17'd256; run_dir = 1'b1;
    @(negedge clk); run = 1'b0;
    chk("R12 first req not yet", mreq_valid, 0);
    @(negedge clk);
    chk("R12 first req at 2 cycles", mreq_valid, 1);
    while (!done) @(negedge clk);
    chk("R12 done 2 after last burst", cyc - last_acc, 2);
    res = result;
    @(negedge clk);
    chk("R1 fetch count", f_cnt, 1);
    chk("R1 fetch addr", f_addr[0], 32'h1000);
    chk("R6 burst addr", b_addr[0], 32'h2000_0000);
    chk("R6 burst len", b_len[0], 256);
    chk("R10 write dir", b_wr[0], 1);
    chk("R7 exact fill with last", res, 1);
  endtask

  task automatic t_multi_carry();
    clr_log();
    put_desc(32'h3000, 32'h0000_3000, 32'h0000_0065);
    put_desc(32'h3008, 32'h0000_5000, 32'h8000_0200);
    do_start(32'h3000);
    do_run(17'd300, 1'b0);
    chk("R1 two fetches", f_cnt, 2);
    chk("R1 second fetch addr", f_addr[1], 32'h3008);
    chk("R2 bit0 dropped len", b_len[0], 100);
    chk("R6 split len", b_len[1], 200);
    chk("R6 split off", b_off[1], 100);
    chk("R6 split addr", b_addr[1], 32'h5000);
    chk("R10 read dir", b_wr[1], 0);
    chk("R7 complete", res, 1);
    clr_log();
    do_run(17'd100, 1'b0);
    chk("R8 no fetch on carry", f_cnt, 0);
    chk("R8 carry addr", b_addr[0], 32'h50C8);
    chk("R8 carry off restarts", b_off[0], 0);
    clr_log();
    do_run(17'd300, 1'b0);
    chk("R4 remaining len", b_len[0], 212);
    chk("R4 table ended", res, 2);
    chk("R4 no fetch after last", f_cnt, 0);
  endtask

  task automatic t_big();
    clr_log();
    put_desc(32'h6000, 32'h0001_0000, 32'hFFFF_0000);
    do_start(32'h6000);
    do_run(17'd70000, 1'b1);
    chk("R3 zero count is 64K", b_len[0], 17'h10000);
    chk("R2 high bits ignored burst count", b_cnt, 1);
    chk("R4 table ended 64K", res, 2);
  endtask

  task automatic t_page();
    clr_log();
    for (int i = 0; i < 520; i++) put_desc(32'h8000 + 32'(i) * 8, 32'h0010_0000 + 32'(i) * 16, 32'h0000_0002);
    do_start(32'h8000);
    do_run(17'd2000, 1'b1);
    chk("R5 fetches within page", f_cnt, 512);
    chk("R5 last fetch addr", f_addr[511], 32'h8FF8);
    chk("R5 bursts", b_cnt, 512);
    chk("R5 last off", b_off[511], 1022);
    chk("R5 table ended by page", res, 2);
  endtask

  task automatic t_backpressure();
    clr_log();
    bp = 1'b1;
    put_desc(32'h9000, 32'h0000_4000, 32'h0000_0010);
    put_desc(32'h9008, 32'h0000_6000, 32'h8000_0010);
    do_start(32'h9000);
    do_run(17'd32, 1'b1);
    bp = 1'b0;
    chk("R11 burst count", b_cnt, 2);
    chk("R11 addr0", b_addr[0], 32'h4000);
    chk("R11 addr1", b_addr[1], 32'h6000);
    chk("R11 off1", b_off[1], 16);
    chk("R11 result", res, 1);
  endtask

  task automatic t_restart();
    clr_log();
    put_desc(32'hA000, 32'h0000_7000, 32'h8000_0040);
    put_desc(32'hB000, 32'h0000_7800, 32'h8000_0020);
    do_start(32'hA000);
    do_run(17'd16, 1'b0);
    clr_log();
    do_start(32'hB000);
    do_run(17'd8, 1'b0);
    chk("R9 new fetch", f_cnt, 1);
    chk("R9 fetch from new base", f_addr[0], 32'hB000);
    chk("R9 new region addr", b_addr[0], 32'h7800);
    chk("R9 result", res, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_single();
    t_multi_carry();
    t_big();
    t_page();
    t_backpressure();
    t_restart();
    summary();
  end
endmodule